// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs read and write transactions to an external Ethernet PHY over a two-wire management bus. One wire is a clock, MDC, that the block generates. The other is a shared data wire, MDIO, that the block drives or releases through an output-enable. A host sets the PHY address, register address, direction and write data, then pulses `start_i`. The block then shifts out a complete 65-bit management frame. On a read it releases the wire at the turnaround and collects the 16 data bits that the PHY returns.

The length of each MDC half-period, counted in system clocks, comes from a run-time input. A reset-poll mode is also available for bringing up a PHY after its reset. In this mode the block keeps reading control register 0 of the selected PHY. It stops when the self-clearing reset flag in bit 15 is low. It also stops when a read budget given by the host is spent, and in that case it raises a timeout flag.

Top module: `mdio_master`

## Requirements
- R1: While `rst_n` is low and after it is released, `mdc_o` is low, `mdio_oe_o` is low (MDIO released), and `busy_o`, `done_o` and `timeout_o` are low.
- R2: A write frame has 65 bit periods. In order they carry: 32 ones, start 0 then 1, opcode 0 then 1, the 5-bit PHY address MSB first, the 5-bit register address MSB first, turnaround 1 then 0, and the 16 write-data bits MSB first. The block drives the first 64 bits and releases MDIO for the 65th (idle) bit.
- R3: A read frame drives 32 ones, start 0 then 1, opcode 1 then 0, and the two addresses MSB first, 46 bits in all. It releases MDIO from the first turnaround bit through the idle bit. The 16 bits the PHY returns in bit periods 48..63 land in `rdata_o`, with the first returned bit as bit 15.
- R4: MDC stays low for exactly `half_wait_i` system clocks and then high for exactly `half_wait_i` system clocks in each bit period. A value of 0 acts as 1.
- R5: `mdio_o` and `mdio_oe_o` change only when MDC falls or while it is low. They hold steady throughout each high phase. MDIO is read on the rising MDC edge.
- R6: `busy_o` goes high on the clock after `start_i` is accepted and stays high until the transaction ends. `done_o` is then high for exactly one clock, in the same clock that `busy_o` falls.
- R7: A `start_i` pulse that arrives while `busy_o` is high has no effect. The current frame goes on unchanged, and no further frame and no second `done_o` follow.
- R8: With `poll_i` set at start, the block issues back-to-back reads of register 0 at the given PHY address. The write-data and register inputs are ignored. It ends with `done_o` and `timeout_o` low as soon as a read returns bit 15 clear, and `rdata_o` then holds that value.
- R9: In poll mode, if `poll_limit_i` reads in a row all return bit 15 set, the block stops after the last of them. It raises `timeout_o` in the same clock as `done_o`, and a limit of 0 acts as 1. `timeout_o` stays high until the next accepted start clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle request to begin a transaction |
| rd_i | input | 1 | 1 selects a read, 0 a write (ignored in poll mode) |
| poll_i | input | 1 | 1 selects the reset-poll sequence |
| phy_addr_i | input | 5 | Target PHY address |
| reg_addr_i | input | 5 | Target register address |
| wdata_i | input | 16 | Write data |
| half_wait_i | input | WAIT_W | System clocks per MDC half-period |
| poll_limit_i | input | LIMIT_W | Maximum number of reads in poll mode |
| mdio_i | input | 1 | MDIO level seen at the pad |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO drive value |
| mdio_oe_o | output | 1 | MDIO output-enable (1 = drive) |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle end-of-transaction pulse |
| rdata_o | output | 16 | Last data read from the PHY |
| timeout_o | output | 1 | Poll sequence gave up |

## Verification
The bench models a PHY that records every driven bit on rising MDC and answers reads on falling MDC. The turnaround ownership is a key corner case. A master that drove the first turnaround bit on a read would fight the PHY, and the recorded enable pattern would show it. One that kept driving on the idle bit after a write would also show up there. The bench measures the MDC phase widths at a wait of 3 and at the degenerate value 0. An off-by-one in the phase counter would stretch or shrink every bit period.

In poll mode the bench checks the exact number of reads against the limit. A design that counted one read too many or too few before giving up would be caught. The bench also sets a limit of 0 to confirm it does not spin forever. It sends a start in the middle of a frame and checks that the frame and the single completion pulse are untouched. It confirms that a plain transaction after a timeout clears the timeout flag.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int PRE_BITS   = 32;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 16;
  localparam int ST_POS     = PRE_BITS;
  localparam int OP_POS     = ST_POS + 2;
  localparam int PHY_POS    = OP_POS + 2;
  localparam int REG_POS    = PHY_POS + ADDR_W;
  localparam int TA_POS     = REG_POS + ADDR_W;
  localparam int DAT_POS    = TA_POS + 2;
  localparam int IDLE_POS   = DAT_POS + DATA_W;
  localparam int FRAME_BITS = IDLE_POS + 1;
  localparam int IDX_W      = $clog2(FRAME_BITS);

  typedef enum logic [1:0] {
    CT_IDLE,
    CT_LAUNCH,
    CT_RUN
  } ctl_state_e;

  typedef struct packed {
    logic oe;
    logic d;
  } drive_t;

  // Pin state for one bit period of a frame.
  function automatic drive_t bit_drive(input logic [IDX_W-1:0] idx,
                                       input logic rd,
                                       input logic [ADDR_W-1:0] phy,
                                       input logic [ADDR_W-1:0] rga,
                                       input logic [DATA_W-1:0] wd);
    int     i;
    drive_t r;
    i = int'(idx);
    if (i < ST_POS)             r = '{oe: 1'b1, d: 1'b1};
    else if (i == ST_POS)       r = '{oe: 1'b1, d: 1'b0};
    else if (i == ST_POS + 1)   r = '{oe: 1'b1, d: 1'b1};
    else if (i == OP_POS)       r = '{oe: 1'b1, d: rd};
    else if (i == OP_POS + 1)   r = '{oe: 1'b1, d: ~rd};
    else if (i < REG_POS)       r = '{oe: 1'b1, d: phy[REG_POS - 1 - i]};
    else if (i < TA_POS)        r = '{oe: 1'b1, d: rga[TA_POS - 1 - i]};
    else if (i == TA_POS)       r = '{oe: ~rd, d: ~rd};
    else if (i == TA_POS + 1)   r = '{oe: ~rd, d: 1'b0};
    else if (i < IDLE_POS)      r = '{oe: ~rd, d: ~rd & wd[IDLE_POS - 1 - i]};
    else                        r = '{oe: 1'b0, d: 1'b0};
    return r;
  endfunction

endpackage

// File: rtl/mdio_mdc_timer.sv
module mdio_mdc_timer #(
  parameter int WAIT_W = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [WAIT_W-1:0] half_wait,
  output logic              tick
);

  logic [WAIT_W-1:0] cnt_q, cnt_d;
  logic [WAIT_W-1:0] last_cnt;

  always_comb begin
    last_cnt = (half_wait == '0) ? '0 : half_wait - 1'b1;
    tick     = run && (cnt_q == last_cnt);
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              rd,
  input  logic [ADDR_W-1:0] phy,
  input  logic [ADDR_W-1:0] rga,
  input  logic [DATA_W-1:0] wd,
  input  logic              tick,
  input  logic              mdio_i,
  output logic              active,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [DATA_W-1:0] rdata,
  output logic              frame_done
);

  localparam logic [IDX_W-1:0] IDX_DAT  = IDX_W'(DAT_POS);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(IDLE_POS);

  logic              active_q, active_d;
  logic              phase_q, phase_d;   // 0 = low half, 1 = high half
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              mdc_q, mdc_d;
  drive_t            drv_q, drv_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              fdone_q, fdone_d;
  logic              in_data;

  assign in_data = (idx_q >= IDX_DAT) && (idx_q < IDX_LAST);

  always_comb begin
    active_d = active_q;
    phase_d  = phase_q;
    idx_d    = idx_q;
    mdc_d    = mdc_q;
    drv_d    = drv_q;
    rdata_d  = rdata_q;
    fdone_d  = 1'b0;
    if (!active_q) begin
      if (go) begin
        active_d = 1'b1;
        phase_d  = 1'b0;
        idx_d    = '0;
        mdc_d    = 1'b0;
        drv_d    = bit_drive('0, rd, phy, rga, wd);
      end
    end else if (tick) begin
      if (!phase_q) begin
        mdc_d   = 1'b1;
        phase_d = 1'b1;
        if (rd && in_data) rdata_d = {rdata_q[DATA_W-2:0], mdio_i};
      end else begin
        mdc_d   = 1'b0;
        phase_d = 1'b0;
        if (idx_q == IDX_LAST) begin
          active_d = 1'b0;
          drv_d    = '0;
          fdone_d  = 1'b1;
        end else begin
          idx_d = idx_q + 1'b1;
          drv_d = bit_drive(idx_q + 1'b1, rd, phy, rga, wd);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      phase_q  <= 1'b0;
      idx_q    <= '0;
      mdc_q    <= 1'b0;
      drv_q    <= '0;
      rdata_q  <= '0;
      fdone_q  <= 1'b0;
    end else begin
      active_q <= active_d;
      phase_q  <= phase_d;
      idx_q    <= idx_d;
      mdc_q    <= mdc_d;
      drv_q    <= drv_d;
      rdata_q  <= rdata_d;
      fdone_q  <= fdone_d;
    end
  end

  assign active     = active_q;
  assign mdc        = mdc_q;
  assign mdio_o     = drv_q.d;
  assign mdio_oe    = drv_q.oe;
  assign rdata      = rdata_q;
  assign frame_done = fdone_q;

  // R5: pin drive may move only with MDC low
  p_drive_on_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(drv_q)) |-> !mdc_q);
  // R5: pin drive frozen across a high phase
  p_stable_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc_q && $past(mdc_q)) |-> $stable(drv_q));
  // R1: idle engine keeps MDC low and MDIO released
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !$past(active_q)) |-> (!mdc_q && !drv_q.oe));

endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int LIMIT_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               rd_i,
  input  logic               poll_i,
  input  logic [ADDR_W-1:0]  phy_i,
  input  logic [ADDR_W-1:0]  reg_i,
  input  logic [DATA_W-1:0]  wd_i,
  input  logic [LIMIT_W-1:0] limit_i,
  input  logic               frame_done,
  input  logic               reset_bit,
  output logic               go,
  output logic               busy,
  output logic               done,
  output logic               timeout,
  output logic               rd_q,
  output logic [ADDR_W-1:0]  phy_q,
  output logic [ADDR_W-1:0]  reg_q,
  output logic [DATA_W-1:0]  wd_q
);

  ctl_state_e         state_q, state_d;
  logic               poll_q, poll_d;
  logic               rd_d;
  logic [ADDR_W-1:0]  phy_d, reg_d;
  logic [DATA_W-1:0]  wd_d;
  logic [LIMIT_W-1:0] limit_q, limit_d;
  logic [LIMIT_W-1:0] cnt_q, cnt_d;
  logic [LIMIT_W:0]   reads_done;
  logic               done_q, done_d;
  logic               tmo_q, tmo_d;

  assign reads_done = {1'b0, cnt_q} + 1'b1;

  always_comb begin
    state_d = state_q;
    poll_d  = poll_q;
    rd_d    = rd_q;
    phy_d   = phy_q;
    reg_d   = reg_q;
    wd_d    = wd_q;
    limit_d = limit_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    tmo_d   = tmo_q;
    unique case (state_q)
      CT_IDLE: if (start_i) begin
        poll_d  = poll_i;
        rd_d    = rd_i | poll_i;
        phy_d   = phy_i;
        reg_d   = poll_i ? '0 : reg_i;
        wd_d    = wd_i;
        limit_d = (limit_i == '0) ? LIMIT_W'(1) : limit_i;
        cnt_d   = '0;
        tmo_d   = 1'b0;
        state_d = CT_LAUNCH;
      end
      CT_LAUNCH: state_d = CT_RUN;
      CT_RUN: if (frame_done) begin
        if (!poll_q || !reset_bit) begin
          done_d  = 1'b1;
          state_d = CT_IDLE;
        end else if (reads_done >= {1'b0, limit_q}) begin
          done_d  = 1'b1;
          tmo_d   = 1'b1;
          state_d = CT_IDLE;
        end else begin
          cnt_d   = cnt_q + 1'b1;
          state_d = CT_LAUNCH;
        end
      end
      default: state_d = CT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CT_IDLE;
      poll_q  <= 1'b0;
      rd_q    <= 1'b0;
      phy_q   <= '0;
      reg_q   <= '0;
      wd_q    <= '0;
      limit_q <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      poll_q  <= poll_d;
      rd_q    <= rd_d;
      phy_q   <= phy_d;
      reg_q   <= reg_d;
      wd_q    <= wd_d;
      limit_q <= limit_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
      tmo_q   <= tmo_d;
    end
  end

  assign go      = (state_q == CT_LAUNCH);
  assign busy    = (state_q != CT_IDLE);
  assign done    = done_q;
  assign timeout = tmo_q;

  // R6: accepted start raises busy on the next clock
  p_busy_after_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy) |=> busy);
  // R6: done lasts one clock and coincides with busy dropping
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  // R7: transaction fields frozen while busy
  p_fields_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(phy_q) && $stable(reg_q) && $stable(rd_q) && $stable(wd_q)));
  // R9: timeout rises only together with done
  p_timeout_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> done);

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int WAIT_W  = 31,
  parameter int LIMIT_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               rd_i,
  input  logic               poll_i,
  input  logic [4:0]         phy_addr_i,
  input  logic [4:0]         reg_addr_i,
  input  logic [15:0]        wdata_i,
  input  logic [WAIT_W-1:0]  half_wait_i,
  input  logic [LIMIT_W-1:0] poll_limit_i,
  input  logic               mdio_i,
  output logic               mdc_o,
  output logic               mdio_o,
  output logic               mdio_oe_o,
  output logic               busy_o,
  output logic               done_o,
  output logic [15:0]        rdata_o,
  output logic               timeout_o
);

  logic              rst_meta_q, rst_sync_n;
  logic              go, tick, active, frame_done;
  logic              rd_q;
  logic [ADDR_W-1:0] phy_q, reg_q;
  logic [DATA_W-1:0] wd_q, rdata;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  mdio_ctrl #(.LIMIT_W(LIMIT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start_i    (start_i),
    .rd_i       (rd_i),
    .poll_i     (poll_i),
    .phy_i      (phy_addr_i),
    .reg_i      (reg_addr_i),
    .wd_i       (wdata_i),
    .limit_i    (poll_limit_i),
    .frame_done (frame_done),
    .reset_bit  (rdata[DATA_W-1]),
    .go         (go),
    .busy       (busy_o),
    .done       (done_o),
    .timeout    (timeout_o),
    .rd_q       (rd_q),
    .phy_q      (phy_q),
    .reg_q      (reg_q),
    .wd_q       (wd_q)
  );

  mdio_mdc_timer #(.WAIT_W(WAIT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .run       (active),
    .half_wait (half_wait_i),
    .tick      (tick)
  );

  mdio_frame u_frame (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .go         (go),
    .rd         (rd_q),
    .phy        (phy_q),
    .rga        (reg_q),
    .wd         (wd_q),
    .tick       (tick),
    .mdio_i     (mdio_i),
    .active     (active),
    .mdc        (mdc_o),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe_o),
    .rdata      (rdata),
    .frame_done (frame_done)
  );

  assign rdata_o = rdata;

endmodule

// File: tb/mdio_master_bench.sv
module mdio_master_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, rd_i = 1'b0, poll_i = 1'b0;
  logic [4:0]  phy_addr_i = '0, reg_addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [30:0] half_wait_i = 31'd2;
  logic [31:0] poll_limit_i = 32'd1;
  logic        mdio_i = 1'b1;
  logic        mdc_o, mdio_o, mdio_oe_o, busy_o, done_o, timeout_o;
  logic [15:0] rdata_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // PHY model state
  int          k = 0;
  int          frame_cnt = 0;
  int          base_frame = 0;
  int          busy_frames = 0;
  logic [15:0] final_resp = 16'h0000;
  logic [64:0] cap_d = '0, cap_oe = '0;
  logic [64:0] wk_d = '0, wk_oe = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_master u_mdio_master (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_i(rd_i), .poll_i(poll_i),
    .phy_addr_i(phy_addr_i), .reg_addr_i(reg_addr_i), .wdata_i(wdata_i),
    .half_wait_i(half_wait_i), .poll_limit_i(poll_limit_i), .mdio_i(mdio_i),
    .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o), .busy_o(busy_o),
    .done_o(done_o), .rdata_o(rdata_o), .timeout_o(timeout_o)
  );

  // capture on rising MDC
  always @(posedge mdc_o) begin
    wk_d[64-k]  = mdio_o;
    wk_oe[64-k] = mdio_oe_o;
    k = k + 1;
    if (k == 65) begin
      cap_d = wk_d;
      cap_oe = wk_oe;
      frame_cnt = frame_cnt + 1;
      k = 0;
    end
  end

  // respond on falling MDC for the upcoming bit index k
  always @(negedge mdc_o) begin
    logic [15:0] resp;
    resp = ((frame_cnt - base_frame) < busy_frames) ? 16'h8123 : final_resp;
    if (k == 47)                 mdio_i <= 1'b0;
    else if (k >= 48 && k <= 63) mdio_i <= resp[63-k];
    else                         mdio_i <= 1'b1;
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc == WD_LIMIT) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog: run hung, act=%0d exp<%0d cycles", cyc, WD_LIMIT);
      summary();
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic launch(input bit rd, input bit poll, input logic [4:0] phy,
                        input logic [4:0] rga, input logic [15:0] wd, input int hw, input int lim);
    @(negedge clk);
    rd_i = rd; poll_i = poll; phy_addr_i = phy; reg_addr_i = rga; wdata_i = wd;
    half_wait_i = 31'(hw); poll_limit_i = 32'(lim);
    base_frame = frame_cnt;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done_o && n < 20000) begin
      @(negedge clk);
      n++;
    end
    check(done_o == 1'b1, tag, 64'(n), 64'(20000));
  endtask

  task automatic t_reset();
    check(mdc_o == 0 && mdio_oe_o == 0, "R1 pins at reset", {62'd0, mdc_o, mdio_oe_o}, 64'd0);
    check(busy_o == 0 && done_o == 0 && timeout_o == 0, "R1 flags at reset",
          {61'd0, busy_o, done_o, timeout_o}, 64'd0);
  endtask

  task automatic t_write();
    logic [63:0] exp;
    exp = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h15, 5'h0A, 2'b10, 16'hA5C3};
    launch(1'b0, 1'b0, 5'h15, 5'h0A, 16'hA5C3, 2, 1);
    check(busy_o == 1'b1, "R6 busy after start", {63'd0, busy_o}, 64'd1);
    wait_done("R6 write done");
    check(busy_o == 1'b0, "R6 busy low with done", {63'd0, busy_o}, 64'd0);
    check(cap_d[64:1] == exp, "R2 write bits", cap_d[64:1], exp);
    check(cap_oe == {64'hFFFF_FFFF_FFFF_FFFF, 1'b0}, "R2 write enable pattern",
          cap_oe[63:0], 64'hFFFF_FFFF_FFFF_FFFE);
    @(negedge clk);
    check(done_o == 1'b0, "R6 done one cycle", {63'd0, done_o}, 64'd0);
    check(frame_cnt - base_frame == 1, "R2 one frame", 64'(frame_cnt - base_frame), 64'd1);
  endtask

  task automatic t_read(input logic [15:0] val, input int hw);
    logic [45:0] exp;
    busy_frames = 0; final_resp = val;
    exp = {32'hFFFF_FFFF, 2'b01, 2'b10, 5'h03, 5'h1C};
    launch(1'b1, 1'b0, 5'h03, 5'h1C, 16'hFFFF, hw, 1);
    wait_done("R3 read done");
    check(cap_d[64:19] == exp, "R3 read header", 64'(cap_d[64:19]), 64'(exp));
    check(cap_oe == {46'h3FFF_FFFF_FFFF, 19'd0}, "R3 read release",
          cap_oe[63:0], {45'h1FFF_FFFF_FFFF, 19'd0});
    check(rdata_o == val, "R3 read data", 64'(rdata_o), 64'(val));
  endtask

  task automatic t_timing(input int hw, input int exp_w);
    int hi = 0, lo = 0;
    launch(1'b0, 1'b0, 5'h01, 5'h02, 16'h1234, hw, 1);
    @(posedge mdc_o);
    @(negedge clk);
    while (mdc_o) begin hi++; @(negedge clk); end
    while (!mdc_o) begin lo++; @(negedge clk); end
    check(hi == exp_w, "R4 high phase", 64'(hi), 64'(exp_w));
    check(lo == exp_w, "R4 low phase", 64'(lo), 64'(exp_w));
    wait_done("R4 done");
  endtask

  task automatic t_ignore_start();
    int dn = 0;
    logic [63:0] exp;
    exp = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h07, 5'h11, 2'b10, 16'h0F0F};
    launch(1'b0, 1'b0, 5'h07, 5'h11, 16'h0F0F, 1, 1);
    repeat (30) @(negedge clk);
    rd_i = 1'b1; poll_i = 1'b1; phy_addr_i = 5'h1F; reg_addr_i = 5'h00; wdata_i = 16'hFFFF;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done("R7 done");
    check(cap_d[64:1] == exp, "R7 frame unchanged", cap_d[64:1], exp);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (done_o || busy_o) dn++;
    end
    check(dn == 0, "R7 no extra transaction", 64'(dn), 64'd0);
    check(frame_cnt - base_frame == 1, "R7 single frame", 64'(frame_cnt - base_frame), 64'd1);
  endtask

  task automatic t_poll_ok();
    logic [45:0] exp;
    busy_frames = 3; final_resp = 16'h1140;
    exp = {32'hFFFF_FFFF, 2'b01, 2'b10, 5'h09, 5'h00};
    launch(1'b0, 1'b1, 5'h09, 5'h1B, 16'h5555, 2, 10);
    wait_done("R8 poll done");
    check(frame_cnt - base_frame == 4, "R8 poll read count", 64'(frame_cnt - base_frame), 64'd4);
    check(timeout_o == 1'b0, "R8 no timeout", {63'd0, timeout_o}, 64'd0);
    check(rdata_o == 16'h1140, "R8 final data", 64'(rdata_o), 64'h1140);
    check(cap_d[64:19] == exp, "R8 reads register 0", 64'(cap_d[64:19]), 64'(exp));
  endtask

  task automatic t_poll_timeout(input int lim, input int exp_n);
    busy_frames = 1000; final_resp = 16'h0000;
    launch(1'b0, 1'b1, 5'h02, 5'h00, 16'h0000, 1, lim);
    wait_done("R9 timeout done");
    check(timeout_o == 1'b1, "R9 timeout with done", {63'd0, timeout_o}, 64'd1);
    check(frame_cnt - base_frame == exp_n, "R9 read budget", 64'(frame_cnt - base_frame), 64'(exp_n));
    repeat (5) @(negedge clk);
    check(timeout_o == 1'b1, "R9 timeout held", {63'd0, timeout_o}, 64'd1);
  endtask

  task automatic t_timeout_clear();
    launch(1'b0, 1'b0, 5'h04, 5'h05, 16'h0001, 1, 1);
    check(timeout_o == 1'b0, "R9 cleared by start", {63'd0, timeout_o}, 64'd0);
    wait_done("R9 plain done");
    check(timeout_o == 1'b0, "R9 stays clear", {63'd0, timeout_o}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_write();
    t_read(16'hBEEF, 2);
    t_read(16'h0001, 1);
    t_timing(3, 3);
    t_timing(0, 1);
    t_ignore_start();
    t_poll_ok();
    t_poll_timeout(5, 5);
    t_timeout_clear();
    t_poll_timeout(0, 1);
    summary();
  end

endmodule